// File: doc/BRIEF.md
# Host Bridge Control Register File

This block holds the 32-bit control registers of a PCI host bridge on a simple synchronous bus. It decodes the low 16 bits of a byte address and implements four live windows:
- a small set of address-translation control words;
- a bank of general control words;
- eight interrupt mapping entries whose enable bits gate interrupt lines downstream;
- one reset control and status register.

Every other address reads zero and ignores writes, and no error is raised. The ignored space includes the translation flush range, the DMA error range and the diagnostic and memory-control ranges.

Reads return data one cycle after the read strobe. A write to the reset register can request a system reset, and a power-on indication input tells the block whether a reset is a cold or a warm one. The reset register remembers whether the next reset is to be treated as a power-on reset.

The bus here is a plain register port and not a data stream, so it has no back-pressure: every strobe completes in one cycle. `rd_valid` marks the cycle in which `rdata` holds the result of the read.

Top module: `hbr_regfile`

## Requirements
- R1: `rdata` and a one-cycle `rd_valid` appear in the cycle after `rd_en` is sampled high.
- R2: The translation words at byte offsets 0x200, 0x204 and 0x208 are fully readable and writable. They are zero after a power-on reset.
- R3: The twelve control words at 0x2000 to 0x202C are fully readable and writable. The word index is taken from address bits [5:2].
- R4: Offsets outside the live windows read zero, and writes to them change no register. This covers 0x20C–0x3FF, 0x30–0x4F and 0x2030 upward.
- R5: Mapping entry i lives at 0xC04 + 8·i. A write changes only its bit 31 (the enable). The word at 0xC00 + 8·i reads zero and ignores writes.
- R6: After a power-on reset, mapping entry i holds 0x7C0 | (i << 2) with the enable clear. Output `map_en[i]` equals bit 31 of entry i.
- R7: A warm reset (`por_in` low) clears only the mapping enable bits. The low 31 bits of the entries, the translation words and the control words keep their values.
- R8: The reset register is at 0xF024 only, and 0xF020 reads zero. A power-on reset loads it with 0x80000000.
- R9: A reset-register write keeps data bits 31:27 only. Data bits 31, 28 and 27 clear the matching status bits when set. Bits 30 and 29 become set when written with 1. Bits 26:0 always read zero.
- R10: Writing bit 30 as 1 pulses `sys_rst_req` high for exactly the cycle after the write. It also makes the next warm reset reload the register with 0x80000000. This holds even when bit 29 is written as 1 at the same time.
- R11: Writing bit 29 as 1 while bit 30 is 0 pulses `sys_rst_req` for one cycle. A following warm reset leaves the register unchanged. Writing neither bit gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| por_in | input | 1 | High during a reset means power-on (cold) reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 16 | Byte address (low 16 bits) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read result present |
| sys_rst_req | output | 1 | One-cycle system reset request |
| map_en | output | 8 | Enable bit of each mapping entry |

## Verification
The hardest state to reach from the ports is the pending power-on mark set by a soft power-on write. It is only visible after a later warm reset, so the stimulus writes the soft bits, then pulses `rst_n` with `por_in` low, and reads the register back. Doing this once with the soft external bit alone and once with the soft power-on bit separates the two cases. The same warm reset is used to show that mapping entries lose only their enable.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
  localparam int DW    = 32;
  localparam int AW    = 16;
  localparam int IDX_W = 4;

  typedef enum logic [2:0] {SEL_NONE, SEL_XLAT, SEL_CTL, SEL_MAP, SEL_RST} sel_e;

  localparam logic [AW-1:0] XLAT_BASE = 16'h0200;
  localparam logic [AW-1:0] CTL_BASE  = 16'h2000;
  localparam logic [AW-1:0] MAP_BASE  = 16'h0C00;
  localparam logic [AW-1:0] RST_BASE  = 16'hF020;

  localparam logic [DW-1:0] RST_KEEP = 32'hF800_0000;
  localparam logic [DW-1:0] RST_CLR  = 32'h9800_0000;
  localparam logic [DW-1:0] RST_SET  = 32'h6000_0000;
  localparam logic [DW-1:0] RST_COLD = 32'h8000_0000;
  localparam int B_SPOR = 30;
  localparam int B_SEXT = 29;
endpackage

// File: rtl/hbr_decode.sv
module hbr_decode
  import hbr_pkg::*;
#(
  parameter int XLAT_WORDS  = 3,
  parameter int CTL_WORDS   = 12,
  parameter int MAP_ENTRIES = 8
) (
  input  logic [AW-1:0]    addr,
  output sel_e             sel,
  output logic [IDX_W-1:0] idx
);
  localparam logic [31:0] XL_LO = 32'(XLAT_BASE);
  localparam logic [31:0] XL_HI = XL_LO + 32'(4 * XLAT_WORDS);
  localparam logic [31:0] CT_LO = 32'(CTL_BASE);
  localparam logic [31:0] CT_HI = CT_LO + 32'(4 * CTL_WORDS);
  localparam logic [31:0] MP_LO = 32'(MAP_BASE);
  localparam logic [31:0] MP_HI = MP_LO + 32'(8 * MAP_ENTRIES);
  localparam logic [31:0] RS_LO = 32'(RST_BASE);
  localparam logic [31:0] RS_HI = RS_LO + 32'd8;

  logic [31:0] a;
  assign a = 32'(addr);

  always_comb begin
    sel = SEL_NONE;
    idx = '0;
    if (a >= XL_LO && a < XL_HI) begin
      sel = SEL_XLAT;
      idx = IDX_W'((a - XL_LO) >> 2);
    end else if (a >= CT_LO && a < CT_HI) begin
      sel = SEL_CTL;
      idx = IDX_W'((a - CT_LO) >> 2);
    end else if (a >= MP_LO && a < MP_HI && addr[2]) begin
      sel = SEL_MAP;
      idx = IDX_W'((a - MP_LO) >> 3);
    end else if (a >= RS_LO && a < RS_HI && addr[2]) begin
      sel = SEL_RST;
    end
  end
endmodule

// File: rtl/hbr_wordbank.sv
module hbr_wordbank
  import hbr_pkg::*;
#(
  parameter int WORDS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] word_q [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (init) word_q[i] <= '0;
      else if (rst_n && we && idx == IDX_W'(i)) word_q[i] <= wdata;
    end

    // R2 R3
    wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && idx == IDX_W'(i)) |=> word_q[i] == $past(wdata));
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < WORDS; i++)
      if (idx == IDX_W'(i)) rdata = word_q[i];
  end
endmodule

// File: rtl/hbr_irqmap.sv
module hbr_irqmap
  import hbr_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init,
  input  logic               we,
  input  logic [IDX_W-1:0]   idx,
  input  logic               wen,
  output logic [DW-1:0]      rdata,
  output logic [ENTRIES-1:0] en_out
);
  logic [30:0] low_q [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_out[i] <= 1'b0;
        if (init) low_q[i] <= 31'(32'h7C0 | (32'(i) << 2));
      end else if (we && idx == IDX_W'(i)) begin
        en_out[i] <= wen;
      end
    end

    // R5
    low_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(low_q[i]));
    // R5
    en_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && idx == IDX_W'(i)) |=> en_out[i] == $past(wen));
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (idx == IDX_W'(i)) rdata = {en_out[i], low_q[i]};
  end
endmodule

// File: rtl/hbr_rstctl.sv
module hbr_rstctl
  import hbr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          por_in,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] stat_q,
  output logic          req_q
);
  logic          cold_pend_q;
  logic [DW-1:0] d;
  assign d = wdata & RST_KEEP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q       <= 1'b0;
      cold_pend_q <= 1'b0;
      if (por_in || cold_pend_q) stat_q <= RST_COLD;
    end else begin
      req_q <= we && (d[B_SPOR] || d[B_SEXT]);
      if (we) begin
        stat_q <= (stat_q & ~(d & RST_CLR)) | (d & RST_SET);
        if (d[B_SPOR]) cold_pend_q <= 1'b1;
      end
    end
  end

  // R9
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wdata[31]) |=> !stat_q[31]);
  // R9
  set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wdata[B_SEXT]) |=> stat_q[B_SEXT]);
  // R10
  req_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> $past(we));
endmodule

// File: rtl/hbr_regfile.sv
module hbr_regfile
  import hbr_pkg::*;
#(
  parameter int XLAT_WORDS  = 3,
  parameter int CTL_WORDS   = 12,
  parameter int MAP_ENTRIES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   por_in,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          wdata,
  output logic [DW-1:0]          rdata,
  output logic                   rd_valid,
  output logic                   sys_rst_req,
  output logic [MAP_ENTRIES-1:0] map_en
);
  sel_e             sel;
  logic [IDX_W-1:0] idx;
  logic             init, wr_ok;
  logic [DW-1:0]    xl_rd, ct_rd, mp_rd, rs_q, rd_mux;

  assign init  = !rst_n && por_in;
  assign wr_ok = wr_en && rst_n;

  hbr_decode #(.XLAT_WORDS(XLAT_WORDS), .CTL_WORDS(CTL_WORDS),
               .MAP_ENTRIES(MAP_ENTRIES)) u_dec (
    .addr(addr), .sel(sel), .idx(idx));

  hbr_wordbank #(.WORDS(XLAT_WORDS)) u_xlat (
    .clk(clk), .rst_n(rst_n), .init(init), .we(wr_ok && sel == SEL_XLAT),
    .idx(idx), .wdata(wdata), .rdata(xl_rd));

  hbr_wordbank #(.WORDS(CTL_WORDS)) u_ctl (
    .clk(clk), .rst_n(rst_n), .init(init), .we(wr_ok && sel == SEL_CTL),
    .idx(idx), .wdata(wdata), .rdata(ct_rd));

  hbr_irqmap #(.ENTRIES(MAP_ENTRIES)) u_map (
    .clk(clk), .rst_n(rst_n), .init(init), .we(wr_ok && sel == SEL_MAP),
    .idx(idx), .wen(wdata[31]), .rdata(mp_rd), .en_out(map_en));

  hbr_rstctl u_rst (
    .clk(clk), .rst_n(rst_n), .por_in(por_in), .we(wr_ok && sel == SEL_RST),
    .wdata(wdata), .stat_q(rs_q), .req_q(sys_rst_req));

  always_comb begin
    case (sel)
      SEL_XLAT: rd_mux = xl_rd;
      SEL_CTL:  rd_mux = ct_rd;
      SEL_MAP:  rd_mux = mp_rd;
      SEL_RST:  rd_mux = rs_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end

  // R1
  rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_en) && $past(rst_n)) |-> rd_valid);
  // R1
  rd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en));
  // R4
  void_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(sel == SEL_NONE)) |-> rdata == '0);
endmodule

// File: tb/sim_hbr_regfile.sv
module sim_hbr_regfile;
  logic        clk = 1'b0, rst_n = 1'b0, por_in = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        rd_valid, sys_rst_req;
  logic [7:0]  map_en;
  int total = 0, bad = 0;
  logic pulse_now, pulse_next;

  hbr_regfile u0 (.clk(clk), .rst_n(rst_n), .por_in(por_in), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .rd_valid(rd_valid), .sys_rst_req(sys_rst_req), .map_en(map_en));

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; pulse_now = sys_rst_req;
    @(negedge clk); pulse_next = sys_rst_req;
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a, input logic [31:0] exp);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    if (!rd_valid) begin total++; bad++; $display("FAIL R1 rd_valid act=0 exp=1"); end
    chk(req, rdata, exp);
    @(negedge clk);
    if (rd_valid) begin total++; bad++; $display("FAIL R1 rd_valid act=1 exp=0"); end
  endtask

  task automatic do_reset(input logic cold);
    @(negedge clk); rst_n = 1'b0; por_in = cold;
    @(negedge clk); @(negedge clk); rst_n = 1'b1; por_in = 1'b0;
  endtask

  task automatic t_power_on;
    do_reset(1'b1);
    chk("R6 map_en", {24'b0, map_en}, 32'h0);
    chk("R10 no req", {31'b0, sys_rst_req}, 32'h0);
    for (int i = 0; i < 8; i++) rd_chk("R6 entry", 16'(16'hC04 + 8 * i), 32'h7C0 | (i << 2));
    rd_chk("R8 rst reg", 16'hF024, 32'h8000_0000);
    rd_chk("R8 even word", 16'hF020, 32'h0);
    rd_chk("R2 cold zero", 16'h0204, 32'h0);
  endtask

  task automatic t_xlat_ctl;
    for (int i = 0; i < 3; i++) wr(16'(16'h200 + 4 * i), 32'hA5A5_0000 + i);
    for (int i = 0; i < 3; i++) rd_chk("R2 xlat", 16'(16'h200 + 4 * i), 32'hA5A5_0000 + i);
    for (int i = 0; i < 12; i++) wr(16'(16'h2000 + 4 * i), 32'h1234_0000 ^ (i * 32'h0101_0101));
    for (int i = 0; i < 12; i++) rd_chk("R3 ctl", 16'(16'h2000 + 4 * i), 32'h1234_0000 ^ (i * 32'h0101_0101));
  endtask

  task automatic t_ignored;
    logic [15:0] holes [7] = '{16'h020C, 16'h0210, 16'h03FC, 16'h0030, 16'h004C, 16'h2030, 16'h1000};
    for (int i = 0; i < 7; i++) begin
      wr(holes[i], 32'hFFFF_FFFF);
      rd_chk("R4 hole", holes[i], 32'h0);
    end
    rd_chk("R4 xlat kept", 16'h0208, 32'hA5A5_0002);
    rd_chk("R4 ctl kept", 16'h202C, 32'h1234_0000 ^ (11 * 32'h0101_0101));
  endtask

  task automatic t_map;
    wr(16'hC0C, 32'hFFFF_FFFF);
    rd_chk("R5 only enable", 16'hC0C, 32'h8000_07C4);
    chk("R6 map_en bit1", {24'b0, map_en}, 32'h02);
    wr(16'hC04, 32'h0000_1234);
    rd_chk("R5 low kept", 16'hC04, 32'h0000_07C0);
    wr(16'hC3C, 32'h8000_0000);
    rd_chk("R5 entry7", 16'hC3C, 32'h8000_07DC);
    chk("R6 map_en", {24'b0, map_en}, 32'h82);
    wr(16'hC08, 32'h0);
    rd_chk("R5 even word", 16'hC08, 32'h0);
    rd_chk("R5 entry1 kept", 16'hC0C, 32'h8000_07C4);
    chk("R5 map_en kept", {24'b0, map_en}, 32'h82);
  endtask

  task automatic t_warm;
    do_reset(1'b0);
    chk("R7 enables cleared", {24'b0, map_en}, 32'h0);
    rd_chk("R7 entry1 low", 16'hC0C, 32'h0000_07C4);
    rd_chk("R7 xlat kept", 16'h0200, 32'hA5A5_0000);
    rd_chk("R7 ctl kept", 16'h2004, 32'h1234_0000 ^ 32'h0101_0101);
  endtask

  task automatic t_rst_reg;
    wr(16'hF024, 32'h8000_0000);
    chk("R11 no pulse", {31'b0, pulse_now}, 32'h0);
    rd_chk("R9 w1c", 16'hF024, 32'h0);
    wr(16'hF020, 32'h4000_0000);
    chk("R8 even no pulse", {31'b0, pulse_now}, 32'h0);
    rd_chk("R8 even ignored", 16'hF024, 32'h0);
    wr(16'hF024, 32'h2000_0000);
    chk("R11 pulse", {31'b0, pulse_now}, 32'h1);
    chk("R11 one cycle", {31'b0, pulse_next}, 32'h0);
    rd_chk("R9 set ext", 16'hF024, 32'h2000_0000);
    do_reset(1'b0);
    rd_chk("R11 warm keeps", 16'hF024, 32'h2000_0000);
    wr(16'hF024, 32'h6000_0000);
    chk("R10 pulse", {31'b0, pulse_now}, 32'h1);
    chk("R10 one cycle", {31'b0, pulse_next}, 32'h0);
    rd_chk("R9 both set", 16'hF024, 32'h6000_0000);
    do_reset(1'b0);
    rd_chk("R10 cold mark", 16'hF024, 32'h8000_0000);
    wr(16'hF024, 32'h7FFF_FFFF);
    chk("R10 pulse again", {31'b0, pulse_now}, 32'h1);
    rd_chk("R9 masked", 16'hF024, 32'hE000_0000);
    do_reset(1'b0);
    rd_chk("R10 cold mark again", 16'hF024, 32'h8000_0000);
  endtask

  initial begin
    #4_000_000;
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_power_on();
    t_xlat_ctl();
    t_ignored();
    t_map();
    t_warm();
    t_rst_reg();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule